// File: doc/BRIEF.md
# Memory Access Region and Permission Checker

This block decides what happens to every 32-bit memory access before it reaches the memory system. It takes an address, the kind of access (load, store or instruction fetch), the current privilege level and a probe flag. It then settles the access in one of three ways. It can map it one to one without translation. It can reject it at once because a user-mode access falls in the supervisor-only region. Otherwise it sends the virtual page number to an external TLB lookup port and judges the answer. That answer is a hit or miss, a physical page number and three permission bits.

The result leaves as a one-cycle `res_valid` pulse. It carries a status (mapped, fault, or not mapped), a cause code and the physical address. A real fault updates three registers that the exception handler reads: the bad-address register, the page-table-entry address register and the data-access flag. A probe access reports "not mapped" in place of a fault and leaves all three registers untouched. The TLB storage and its refill are outside this block.

The control is a three-state machine. `ST_IDLE` accepts a request (`req_ready` high). It moves to `ST_LOOKUP` when translation is needed, and directly to `ST_DONE` for an identity-mapped or supervisor-only result. `ST_LOOKUP` drives `tlb_req_valid` and waits for `tlb_rsp_valid`, then moves to `ST_DONE`. `ST_DONE` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `mem_access_checker`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` and `tlb_req_valid` are 0, and `bad_addr`, `pte_addr` and `tlbmisc_data` are all 0.
- R2: When `cfg_mmu_en` is 0, every access yields status MAPPED (0) with `res_paddr` equal to `req_addr`. It never issues a lookup, whatever the privilege or address.
- R3: When `cfg_mmu_en` is 1 and `req_super` is 1, an address at or above 0xC0000000 yields MAPPED with `res_paddr` equal to the address, with no lookup. A supervisor address from 0x80000000 to 0xBFFFFFFF is translated like any other.
- R4: When `cfg_mmu_en` is 1 and `req_super` is 0, an address at or above 0x80000000 yields status FAULT (1) with cause 9, with no lookup. It writes the address to `bad_addr` and leaves `pte_addr` and `tlbmisc_data` unchanged.
- R5: On a lookup hit whose permission allows the access, the status is MAPPED and `res_paddr` is {`tlb_rsp_pfn`, address[11:0]}. `tlb_rsp_perm` bit 0 allows loads, bit 1 stores and bit 2 fetches. `req_kind` encodes 0 load, 1 store, and 2 or 3 fetch.
- R6: On a hit whose matching permission bit is 0, the status is FAULT with cause 13 for a load, 14 for a store or 15 for a fetch.
- R7: On a lookup miss, the status is FAULT with cause 12, whatever the access kind.
- R8: On a translation fault (cause 12 to 15), `tlbmisc_data` becomes 0 for a fetch and 1 for a load or store.
- R9: On a translation fault, `pte_addr`[21:2] takes address[31:12], `pte_addr`[31:22] keeps its base value, `pte_addr`[1:0] stays 0, and `bad_addr` takes the address.
- R10: With `req_probe` at 1, any access that would fault yields status NOMAP (2) instead, and `bad_addr`, `pte_addr` and `tlbmisc_data` are left unchanged.
- R11: `res_valid` is a single-cycle pulse. It comes one cycle after acceptance for an untranslated access, or one cycle after the `tlb_rsp_valid` cycle. `tlb_req_valid` stays high with `tlb_req_vpn` equal to address[31:12] until the response arrives.
- R12: A cycle with `pt_base_ld` at 1 loads `pt_base_val` into `pte_addr`[31:22] and does not disturb the page-number field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mmu_en | input | 1 | 1 when address translation is configured |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Virtual address of the access |
| req_kind | input | 2 | 0 load, 1 store, 2/3 fetch |
| req_super | input | 1 | 1 for supervisor mode |
| req_probe | input | 1 | 1 to test the mapping without faulting |
| tlb_req_valid | output | 1 | Lookup request to the TLB |
| tlb_req_vpn | output | 20 | Virtual page number to look up |
| tlb_rsp_valid | input | 1 | Lookup response present |
| tlb_rsp_hit | input | 1 | Lookup found an entry |
| tlb_rsp_pfn | input | 20 | Physical page number of the entry |
| tlb_rsp_perm | input | 3 | Entry permissions: bit0 read, bit1 write, bit2 execute |
| res_valid | output | 1 | Result pulse |
| res_status | output | 2 | 0 mapped, 1 fault, 2 not mapped |
| res_cause | output | 5 | Fault cause code when status is fault or not mapped |
| res_paddr | output | 32 | Physical address when mapped |
| pt_base_ld | input | 1 | Load the page-table base field |
| pt_base_val | input | 10 | New page-table base value |
| bad_addr | output | 32 | Last faulting address |
| pte_addr | output | 32 | Page-table base and faulting page number |
| tlbmisc_data | output | 1 | 1 when the last translation fault was a data access |

## Verification
Suppose the state machine leaves `ST_DONE` late or skips `ST_LOOKUP`. The bench sees a doubled or missing `res_valid` pulse, or a dropped `tlb_req_valid`, in the very cycle the pulse or request is due. A captured request field that was taken wrong shows up in the next result as a wrong cause, address or status. A fault-register update that fires on the wrong path, such as a probe, the supervisor-only fault or a clobbered base field, stays in `bad_addr`, `pte_addr` or `tlbmisc_data`. The bench checks those right after each access, so such an error shows within the access that caused it.

// File: rtl/mem_access_pkg.sv
package mem_access_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_DONE   = 2'd2
    } chk_state_e;

    localparam logic [1:0] STAT_MAPPED = 2'd0;
    localparam logic [1:0] STAT_FAULT  = 2'd1;
    localparam logic [1:0] STAT_NOMAP  = 2'd2;

    localparam logic [4:0] CAUSE_NONE  = 5'd0;
    localparam logic [4:0] CAUSE_SUPER = 5'd9;
    localparam logic [4:0] CAUSE_MISS  = 5'd12;
    localparam logic [4:0] CAUSE_RPERM = 5'd13;
    localparam logic [4:0] CAUSE_WPERM = 5'd14;
    localparam logic [4:0] CAUSE_XPERM = 5'd15;

endpackage

// File: rtl/addr_window.sv
module addr_window #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] KWIN_BASE  = 32'hC000_0000,
    parameter logic [ADDR_W-1:0] SUPER_BASE = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_super,
    input  logic              mmu_en,
    output logic              identity,
    output logic              super_violation,
    output logic              need_xlate
);
    always_comb begin
        identity        = !mmu_en || (is_super && (addr >= KWIN_BASE));
        super_violation = mmu_en && !is_super && (addr >= SUPER_BASE);
        need_xlate      = !identity && !super_violation;
    end
endmodule

// File: rtl/perm_check.sv
module perm_check
    import mem_access_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       hit,
    input  logic [2:0] perm,
    output logic       allowed,
    output logic [4:0] cause
);
    logic needed_bit;

    always_comb begin
        if (kind[1]) begin
            needed_bit = perm[2];
        end else if (kind[0]) begin
            needed_bit = perm[1];
        end else begin
            needed_bit = perm[0];
        end
        allowed = hit && needed_bit;

        if (!hit) begin
            cause = CAUSE_MISS;
        end else if (needed_bit) begin
            cause = CAUSE_NONE;
        end else if (kind[1]) begin
            cause = CAUSE_XPERM;
        end else if (kind[0]) begin
            cause = CAUSE_WPERM;
        end else begin
            cause = CAUSE_RPERM;
        end
    end
endmodule

// File: rtl/fault_regs.sv
module fault_regs #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int VPN_LSB   = 2,
    localparam int VPN_W    = ADDR_W - PAGE_BITS,
    localparam int BASE_W   = ADDR_W - VPN_LSB - VPN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_ld,
    input  logic [BASE_W-1:0] base_val,
    input  logic              upd_bad,
    input  logic              upd_xlate,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic              fault_is_fetch,
    output logic [ADDR_W-1:0] bad_addr_q,
    output logic [ADDR_W-1:0] pte_addr_q,
    output logic              data_flag_q
);
    logic [BASE_W-1:0] base_q;
    logic [VPN_W-1:0]  vpn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_addr_q  <= '0;
            base_q      <= '0;
            vpn_q       <= '0;
            data_flag_q <= 1'b0;
        end else begin
            if (upd_bad) begin
                bad_addr_q <= fault_addr;
            end
            if (base_ld) begin
                base_q <= base_val;
            end
            if (upd_xlate) begin
                vpn_q       <= fault_addr[ADDR_W-1:PAGE_BITS];
                data_flag_q <= !fault_is_fetch;
            end
        end
    end

    assign pte_addr_q = {base_q, vpn_q, {VPN_LSB{1'b0}}};

    // R8: data flag follows the kind of the faulting access
    a_r8_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
        upd_xlate |=> (data_flag_q == !$past(fault_is_fetch)));

    // R12: base field untouched when no base load is requested
    a_r12_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !base_ld |=> $stable(pte_addr_q[ADDR_W-1:ADDR_W-BASE_W]));
endmodule

// File: rtl/mem_access_checker.sv
module mem_access_checker
    import mem_access_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                PAGE_BITS  = 12,
    parameter int                VPN_LSB    = 2,
    parameter logic [ADDR_W-1:0] KWIN_BASE  = 32'hC000_0000,
    parameter logic [ADDR_W-1:0] SUPER_BASE = 32'h8000_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_mmu_en,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [1:0]                     req_kind,
    input  logic                           req_super,
    input  logic                           req_probe,
    output logic                           tlb_req_valid,
    output logic [ADDR_W-PAGE_BITS-1:0]    tlb_req_vpn,
    input  logic                           tlb_rsp_valid,
    input  logic                           tlb_rsp_hit,
    input  logic [ADDR_W-PAGE_BITS-1:0]    tlb_rsp_pfn,
    input  logic [2:0]                     tlb_rsp_perm,
    output logic                           res_valid,
    output logic [1:0]                     res_status,
    output logic [4:0]                     res_cause,
    output logic [ADDR_W-1:0]              res_paddr,
    input  logic                           pt_base_ld,
    input  logic [PAGE_BITS-VPN_LSB-1:0]   pt_base_val,
    output logic [ADDR_W-1:0]              bad_addr,
    output logic [ADDR_W-1:0]              pte_addr,
    output logic                           tlbmisc_data
);
    localparam int VPN_W = ADDR_W - PAGE_BITS;

    chk_state_e state_q, state_d;

    logic [ADDR_W-1:0] cap_addr_q;
    logic [1:0]        cap_kind_q;
    logic              cap_probe_q;
    logic [1:0]        stat_q;
    logic [4:0]        cause_q;
    logic [ADDR_W-1:0] paddr_q;

    logic win_identity, win_violation, win_xlate;
    logic perm_ok;
    logic [4:0] perm_cause;

    logic accept, rsp_take;
    logic upd_bad, upd_xlate;
    logic [ADDR_W-1:0] fault_addr;

    addr_window #(
        .ADDR_W     (ADDR_W),
        .KWIN_BASE  (KWIN_BASE),
        .SUPER_BASE (SUPER_BASE)
    ) u_window (
        .addr            (req_addr),
        .is_super        (req_super),
        .mmu_en          (cfg_mmu_en),
        .identity        (win_identity),
        .super_violation (win_violation),
        .need_xlate      (win_xlate)
    );

    perm_check u_perm (
        .kind    (cap_kind_q),
        .hit     (tlb_rsp_hit),
        .perm    (tlb_rsp_perm),
        .allowed (perm_ok),
        .cause   (perm_cause)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign rsp_take = (state_q == ST_LOOKUP) && tlb_rsp_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = win_xlate ? ST_LOOKUP : ST_DONE;
                end
            end
            ST_LOOKUP: begin
                if (tlb_rsp_valid) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        tlb_req_valid = (state_q == ST_LOOKUP);
        res_valid     = (state_q == ST_DONE);
        tlb_req_vpn   = cap_addr_q[ADDR_W-1:PAGE_BITS];
        res_status    = stat_q;
        res_cause     = cause_q;
        res_paddr     = paddr_q;
    end

    // captured request and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr_q  <= '0;
            cap_kind_q  <= 2'd0;
            cap_probe_q <= 1'b0;
            stat_q      <= STAT_MAPPED;
            cause_q     <= CAUSE_NONE;
            paddr_q     <= '0;
        end else if (accept) begin
            cap_addr_q  <= req_addr;
            cap_kind_q  <= req_kind;
            cap_probe_q <= req_probe;
            paddr_q     <= req_addr;
            if (win_violation) begin
                stat_q  <= req_probe ? STAT_NOMAP : STAT_FAULT;
                cause_q <= CAUSE_SUPER;
            end else begin
                stat_q  <= STAT_MAPPED;
                cause_q <= CAUSE_NONE;
            end
        end else if (rsp_take) begin
            paddr_q <= {tlb_rsp_pfn, cap_addr_q[PAGE_BITS-1:0]};
            cause_q <= perm_cause;
            if (perm_ok) begin
                stat_q <= STAT_MAPPED;
            end else begin
                stat_q <= cap_probe_q ? STAT_NOMAP : STAT_FAULT;
            end
        end
    end

    // fault register updates
    always_comb begin
        upd_xlate  = rsp_take && !perm_ok && !cap_probe_q;
        upd_bad    = upd_xlate || (accept && win_violation && !req_probe);
        fault_addr = accept ? req_addr : cap_addr_q;
    end

    fault_regs #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .VPN_LSB   (VPN_LSB)
    ) u_fregs (
        .clk            (clk),
        .rst_n          (rst_n),
        .base_ld        (pt_base_ld),
        .base_val       (pt_base_val),
        .upd_bad        (upd_bad),
        .upd_xlate      (upd_xlate),
        .fault_addr     (fault_addr),
        .fault_is_fetch (cap_kind_q[1]),
        .bad_addr_q     (bad_addr),
        .pte_addr_q     (pte_addr),
        .data_flag_q    (tlbmisc_data)
    );

    // R11: result is a single-cycle pulse
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R11: lookup request held until a response arrives
    a_r11_lookup_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req_valid && !tlb_rsp_valid) |=> (tlb_req_valid && $stable(tlb_req_vpn)));

    // R4, R9: a reported fault has its address in the bad-address register
    a_r4_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == STAT_FAULT) |-> (bad_addr == cap_addr_q));

    // R10: a probe result never touched the bad-address register
    a_r10_probe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == STAT_NOMAP) |-> $stable(bad_addr));

    // R2: no lookup is ever issued without translation configured
    a_r2_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_mmu_en) |=> !tlb_req_valid);
endmodule

// File: tb/mem_access_checker_tb.sv
module mem_access_checker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mmu_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic        req_probe = 1'b0;
    logic        tlb_req_valid;
    logic [19:0] tlb_req_vpn;
    logic        tlb_rsp_valid = 1'b0;
    logic        tlb_rsp_hit = 1'b0;
    logic [19:0] tlb_rsp_pfn = '0;
    logic [2:0]  tlb_rsp_perm = '0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [4:0]  res_cause;
    logic [31:0] res_paddr;
    logic        pt_base_ld = 1'b0;
    logic [9:0]  pt_base_val = '0;
    logic [31:0] bad_addr;
    logic [31:0] pte_addr;
    logic        tlbmisc_data;

    int n_checks = 0;
    int n_errors = 0;

    // bench model of the fault registers
    logic [31:0] m_bad  = '0;
    logic [9:0]  m_base = '0;
    logic [19:0] m_vpn  = '0;
    logic        m_dflag = 1'b0;

    // last observed result
    logic [1:0]  o_stat;
    logic [4:0]  o_cause;
    logic [31:0] o_paddr;

    always #4 clk = ~clk;

    mem_access_checker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mmu_en    (cfg_mmu_en),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_kind      (req_kind),
        .req_super     (req_super),
        .req_probe     (req_probe),
        .tlb_req_valid (tlb_req_valid),
        .tlb_req_vpn   (tlb_req_vpn),
        .tlb_rsp_valid (tlb_rsp_valid),
        .tlb_rsp_hit   (tlb_rsp_hit),
        .tlb_rsp_pfn   (tlb_rsp_pfn),
        .tlb_rsp_perm  (tlb_rsp_perm),
        .res_valid     (res_valid),
        .res_status    (res_status),
        .res_cause     (res_cause),
        .res_paddr     (res_paddr),
        .pt_base_ld    (pt_base_ld),
        .pt_base_val   (pt_base_val),
        .bad_addr      (bad_addr),
        .pte_addr      (pte_addr),
        .tlbmisc_data  (tlbmisc_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check({tag, " bad_addr"}, bad_addr, m_bad);
        check({tag, " pte_addr"}, pte_addr, {m_base, m_vpn, 2'b00});
        check({tag, " tlbmisc_data"}, {31'd0, tlbmisc_data}, {31'd0, m_dflag});
    endtask

    // one access; lookup=1 means the bench expects and answers a TLB lookup
    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic sup,
                          input logic prb, input logic lookup, input logic hit,
                          input logic [19:0] pfn, input logic [2:0] perm);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = k; req_super = sup; req_probe = prb;
        @(negedge clk);
        req_valid = 1'b0;
        if (lookup) begin
            check("R11 lookup issued", {31'd0, tlb_req_valid}, 32'd1);
            check("R11 lookup vpn", {12'd0, tlb_req_vpn}, {12'd0, a[31:12]});
            check("R11 no early result", {31'd0, res_valid}, 32'd0);
            @(negedge clk);
            check("R11 lookup held", {31'd0, tlb_req_valid}, 32'd1);
            tlb_rsp_valid = 1'b1; tlb_rsp_hit = hit; tlb_rsp_pfn = pfn; tlb_rsp_perm = perm;
            @(negedge clk);
            tlb_rsp_valid = 1'b0;
        end else begin
            check("R2 R3 R4 no lookup", {31'd0, tlb_req_valid}, 32'd0);
        end
        check("R11 result pulse", {31'd0, res_valid}, 32'd1);
        o_stat = res_status; o_cause = res_cause; o_paddr = res_paddr;
        @(negedge clk);
        check("R11 pulse ends", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 res_valid", {31'd0, res_valid}, 32'd0);
        check("R1 tlb_req_valid", {31'd0, tlb_req_valid}, 32'd0);
        check_regs("R1");
    endtask

    task automatic t_no_mmu();
        cfg_mmu_en = 1'b0;
        access(32'h1234_5678, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
        check("R2 status", {30'd0, o_stat}, 32'd0);
        check("R2 paddr", o_paddr, 32'h1234_5678);
        access(32'hF000_0010, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
        check("R2 high user status", {30'd0, o_stat}, 32'd0);
        check("R2 high user paddr", o_paddr, 32'hF000_0010);
        check_regs("R2");
    endtask

    task automatic t_kernel_window();
        cfg_mmu_en = 1'b1;
        access(32'hC000_1004, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
        check("R3 status", {30'd0, o_stat}, 32'd0);
        check("R3 paddr", o_paddr, 32'hC000_1004);
        // supervisor below the window is translated
        access(32'h9000_0010, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 20'hABCDE, 3'b100);
        check("R3 translated status", {30'd0, o_stat}, 32'd0);
        check("R3 translated paddr", o_paddr, 32'hABCD_E010);
    endtask

    task automatic t_super_only();
        access(32'h8000_0040, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
        m_bad = 32'h8000_0040;
        check("R4 status", {30'd0, o_stat}, 32'd1);
        check("R4 cause", {27'd0, o_cause}, 32'd9);
        check_regs("R4");
    endtask

    task automatic t_hit();
        access(32'h0040_2ABC, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h12345, 3'b001);
        check("R5 load status", {30'd0, o_stat}, 32'd0);
        check("R5 load paddr", o_paddr, 32'h1234_5ABC);
        access(32'h0000_3FFF, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00777, 3'b010);
        check("R5 store status", {30'd0, o_stat}, 32'd0);
        check("R5 store paddr", o_paddr, 32'h0077_7FFF);
        check_regs("R5");
    endtask

    task automatic t_perm();
        access(32'h0100_0123, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h11111, 3'b110);
        m_bad = 32'h0100_0123; m_vpn = 20'h01000; m_dflag = 1'b1;
        check("R6 load cause", {27'd0, o_cause}, 32'd13);
        check("R6 load status", {30'd0, o_stat}, 32'd1);
        check_regs("R6 R8 R9 load");
        access(32'h0200_5004, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 20'h22222, 3'b011);
        m_bad = 32'h0200_5004; m_vpn = 20'h02005; m_dflag = 1'b0;
        check("R6 fetch cause", {27'd0, o_cause}, 32'd15);
        check_regs("R6 R8 R9 fetch");
        access(32'h7FFF_F008, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 20'h33333, 3'b101);
        m_bad = 32'h7FFF_F008; m_vpn = 20'h7FFFF; m_dflag = 1'b1;
        check("R6 store cause", {27'd0, o_cause}, 32'd14);
        check_regs("R6 R8 R9 store");
    endtask

    task automatic t_miss();
        access(32'h0ABC_D010, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0, 3'b111);
        m_bad = 32'h0ABC_D010; m_vpn = 20'h0ABCD; m_dflag = 1'b0;
        check("R7 status", {30'd0, o_stat}, 32'd1);
        check("R7 cause", {27'd0, o_cause}, 32'd12);
        check_regs("R7 R8");
    endtask

    task automatic t_probe();
        access(32'h0555_5000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0, 3'b000);
        check("R10 miss status", {30'd0, o_stat}, 32'd2);
        check_regs("R10 miss");
        access(32'hA000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
        check("R10 super-only status", {30'd0, o_stat}, 32'd2);
        check_regs("R10 super-only");
    endtask

    task automatic t_base();
        @(negedge clk);
        pt_base_ld = 1'b1; pt_base_val = 10'h2AB;
        @(negedge clk);
        pt_base_ld = 1'b0;
        m_base = 10'h2AB;
        check_regs("R12 base load");
        access(32'h0001_2345, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0, 3'b000);
        m_bad = 32'h0001_2345; m_vpn = 20'h00012; m_dflag = 1'b1;
        check_regs("R9 R12 base kept");
    endtask

    initial begin
        #2;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_mmu();
        t_kernel_window();
        t_super_only();
        t_hit();
        t_perm();
        t_miss();
        t_probe();
        t_base();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule